// File: doc/BRIEF.md
# Bus Transaction Timeout Monitor

The block watches bus cycles and terminates any cycle that hangs. A cycle begins when the transfer-start strobe is sampled high while the block is idle. From then on a span counter advances once per clock until a transfer acknowledge arrives. If the acknowledge has not arrived when the counter reaches the programmed limit, the block drives a one-clock transfer-error acknowledge. That pulse ends the stuck cycle, and the block returns to idle.

The limit is an 8-bit timing value measured in units of eight system clocks, so the longest wait is 2040 clocks. The timing value and the monitor enable live in a 32-bit control word that is shared with other functions. The block captures only its own fields from a write on a simple register write port. It ignores every other bit of the word.

Top module: `bus_watch_top`

## Requirements
- R1: After synchronous reset, `xfer_err` is low, monitoring is enabled and the timing value is 255.
- R2: A clock with `cfg_we` high loads the enable from `cfg_wdata[7]` (1 = monitoring on) and the timing value from `cfg_wdata[15:8]`. Bits 31:16 and 6:0 of the written word have no effect on timing or enable.
- R3: Let a start be sampled at clock edge E0 while the block is idle, and let the timing value T be between 1 and 255. With no acknowledge, `xfer_err` rises at edge E(8*T) and is visible in the following cycle.
- R4: `xfer_err` is high for exactly one clock. The block is then idle, and it reports nothing more until a new start arrives.
- R5: An acknowledge sampled at any edge up to and including the timeout edge ends the cycle without an error.
- R6: A timing value of 0 times out at the first edge after the start (E1).
- R7: While monitoring is disabled, no error is raised and the span counter is held at zero. Disabling in the middle of a cycle abandons that cycle without an error.
- R8: A start strobe that arrives while a cycle is already being timed is ignored. The timeout is still measured from the first start.
- R9: With the reset timing value of 255, an unacknowledged cycle times out after 2040 clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 32 | Control word write data |
| xfer_start | input | 1 | Transfer-start strobe, one clock per bus cycle |
| xfer_ack | input | 1 | Transfer acknowledge from the addressed target |
| xfer_err | output | 1 | One-clock transfer-error acknowledge on timeout |

## Verification
The assertions assume three things about the inputs. A target acknowledges only a cycle that is in progress. The control word is not rewritten during a timed cycle, except to disable monitoring. The start strobe lasts a single clock. The bench keeps to these rules. It writes the control word only while the block is idle, with one exception: a deliberate disable in mid-cycle. It drives every strobe and acknowledge for exactly one clock. The redundant start that tests R8 is placed well inside a cycle that is already running, so that it cannot be confused with the beginning of a new cycle.

// File: rtl/bus_watch_pkg.sv
package bus_watch_pkg;

    // Width of the programmable timing value
    localparam int TIME_W    = 8;
    // Clocks per timing unit
    localparam int TICK_UNIT = 8;
    // Bit positions inside the shared control word
    localparam int EN_POS    = 7;
    localparam int TIME_LSB  = 8;
    // Span counter width, sized for the longest limit
    localparam int MAX_LIMIT = ((1 << TIME_W) - 1) * TICK_UNIT;
    localparam int CNT_W     = $clog2(MAX_LIMIT + 1);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } watch_state_e;

    typedef struct packed {
        logic              en;
        logic [TIME_W-1:0] timing;
    } watch_cfg_t;

    function automatic logic [CNT_W-1:0] limit_of(input logic [TIME_W-1:0] t);
        logic [CNT_W-1:0] wide;
        wide = CNT_W'(t);
        return wide * CNT_W'(TICK_UNIT);
    endfunction

endpackage

// File: rtl/bw_ctl_reg.sv
module bw_ctl_reg
    import bus_watch_pkg::*;
#(
    parameter int                DATA_W   = 32,
    parameter logic              EN_RST   = 1'b1,
    parameter logic [TIME_W-1:0] TIME_RST = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output watch_cfg_t        cfg
);

    watch_cfg_t cfg_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.en     <= EN_RST;
            cfg_q.timing <= TIME_RST;
        end else if (wr_en) begin
            cfg_q.en     <= wr_data[EN_POS];
            cfg_q.timing <= wr_data[TIME_LSB +: TIME_W];
        end
    end

    assign cfg = cfg_q;

endmodule

// File: rtl/bw_span_timer.sv
module bw_span_timer
    import bus_watch_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             hold_zero,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W:0]   cnt_inc;

    assign cnt_inc = {1'b0, cnt_q} + 1'b1;
    // True when the edge now coming completes the programmed span
    assign expire  = cnt_inc >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || hold_zero) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_inc[CNT_W-1:0];
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/bw_seq.sv
module bw_seq
    import bus_watch_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic start,
    input  logic ack,
    input  logic expire,
    output logic in_wait,
    output logic hold_zero,
    output logic err
);

    watch_state_e state_q, state_d;
    logic         timed_out;
    logic         err_q;

    assign in_wait   = (state_q == ST_WAIT);
    assign timed_out = in_wait && en && !ack && expire;
    assign hold_zero = !in_wait || !en || ack || expire;

    always_comb begin
        state_d = state_q;
        if (!en) begin
            state_d = ST_IDLE;
        end else begin
            case (state_q)
                ST_IDLE: if (start)            state_d = ST_WAIT;
                ST_WAIT: if (ack || timed_out) state_d = ST_IDLE;
                default:                       state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            err_q   <= timed_out;
        end
    end

    assign err = err_q;

endmodule

// File: rtl/bus_watch_top.sv
module bus_watch_top
    import bus_watch_pkg::*;
#(
    parameter int                CFG_W    = 32,
    parameter logic              EN_RST   = 1'b1,
    parameter logic [TIME_W-1:0] TIME_RST = 8'hFF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             xfer_start,
    input  logic             xfer_ack,
    output logic             xfer_err
);

    watch_cfg_t       cfg_q;
    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt_q;
    logic             expire;
    logic             in_wait;
    logic             hold_zero;

    bw_ctl_reg #(
        .DATA_W   (CFG_W),
        .EN_RST   (EN_RST),
        .TIME_RST (TIME_RST)
    ) i_ctl (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_data (cfg_wdata),
        .cfg     (cfg_q)
    );

    assign limit = limit_of(cfg_q.timing);

    bw_span_timer i_timer (
        .clk       (clk),
        .rst       (rst),
        .hold_zero (hold_zero),
        .limit     (limit),
        .cnt       (cnt_q),
        .expire    (expire)
    );

    bw_seq i_seq (
        .clk       (clk),
        .rst       (rst),
        .en        (cfg_q.en),
        .start     (xfer_start),
        .ack       (xfer_ack),
        .expire    (expire),
        .in_wait   (in_wait),
        .hold_zero (hold_zero),
        .err       (xfer_err)
    );

endmodule

// File: rtl/bus_watch_chk.sv
module bus_watch_chk
    import bus_watch_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             xfer_ack,
    input logic             xfer_err,
    input logic             cfg_en,
    input logic             in_wait,
    input logic [CNT_W-1:0] cnt
);

    // R4: the error pulse lasts a single clock
    a_r4_err_single: assert property (@(posedge clk) disable iff (rst)
        xfer_err |=> !xfer_err);

    // R3: an error can only follow a cycle that was being timed
    a_r3_err_after_wait: assert property (@(posedge clk) disable iff (rst)
        xfer_err |-> $past(in_wait));

    // R4: the block is idle in the clock that carries the error
    a_r4_idle_on_err: assert property (@(posedge clk) disable iff (rst)
        xfer_err |-> !in_wait);

    // R5: a sampled acknowledge suppresses the error at that edge
    a_r5_ack_wins: assert property (@(posedge clk) disable iff (rst)
        xfer_ack |=> !xfer_err);

    // R7: no error while monitoring was off
    a_r7_no_err_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !xfer_err);

    // R7: counter cleared when monitoring is off
    a_r7_cnt_clear: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> (cnt == '0));

    // R7: no cycle is timed while monitoring is off
    a_r7_no_wait_off: assert property (@(posedge clk) disable iff (rst)
        !cfg_en |=> !in_wait);

endmodule

bind bus_watch_top bus_watch_chk i_chk (
    .clk      (clk),
    .rst      (rst),
    .xfer_ack (xfer_ack),
    .xfer_err (xfer_err),
    .cfg_en   (cfg_q.en),
    .in_wait  (in_wait),
    .cnt      (cnt_q)
);

// File: tb/test_bus_watch_top.sv
`timescale 1ns/1ps
module test_bus_watch_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        xfer_start = 1'b0;
    logic        xfer_ack = 1'b0;
    logic        xfer_err;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #2.5 clk = ~clk;

    bus_watch_top i_bus_watch_top (
        .clk        (clk),
        .rst        (rst),
        .cfg_we     (cfg_we),
        .cfg_wdata  (cfg_wdata),
        .xfer_start (xfer_start),
        .xfer_ack   (xfer_ack),
        .xfer_err   (xfer_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input logic en, input logic [7:0] t, input logic [31:0] junk);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = (junk & 32'hFFFF_007F) | {16'h0, t, en, 7'h0};
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    // Start pulse; returns at the negedge after E0
    task automatic pulse_start();
        @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
    endtask

    // Wait up to max_k edges; returns the edge index k of the error, or 0
    task automatic watch_err(input int max_k, output int got);
        got = 0;
        for (int k = 1; k <= max_k; k++) begin
            @(negedge clk);
            if (xfer_err) begin
                got = k;
                break;
            end
        end
    endtask

    task automatic t_reset_state();
        check(xfer_err == 1'b0, "R1 err low after reset", int'(xfer_err), 0);
    endtask

    task automatic t_reset_limit();
        int got;
        pulse_start();
        watch_err(2100, got);
        check(got == 2040, "R9 reset timing 255", got, 2040);
        @(negedge clk);
        check(xfer_err == 1'b0, "R4 single pulse", int'(xfer_err), 0);
        watch_err(50, got);
        check(got == 0, "R4 no repeat without start", got, 0);
    endtask

    task automatic t_timeout(input logic [7:0] t, input int exp, input string req);
        int got;
        write_cfg(1'b1, t, 32'h0);
        pulse_start();
        watch_err(exp + 20, got);
        check(got == exp, req, got, exp);
        @(negedge clk);
        check(xfer_err == 1'b0, "R4 pulse one clock", int'(xfer_err), 0);
    endtask

    task automatic t_junk_bits();
        int got;
        write_cfg(1'b1, 8'd5, 32'hFFFF_007F);
        pulse_start();
        watch_err(80, got);
        check(got == 40, "R2 other bits ignored", got, 40);
    endtask

    task automatic t_ack(input int ack_k, input string req);
        int got;
        write_cfg(1'b1, 8'd2, 32'h0);
        pulse_start();
        for (int k = 1; k < ack_k; k++) @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        check(xfer_err == 1'b0, req, int'(xfer_err), 0);
        watch_err(60, got);
        check(got == 0, req, got, 0);
    endtask

    task automatic t_restart_ignored();
        int got;
        write_cfg(1'b1, 8'd4, 32'h0);
        pulse_start();
        for (int k = 1; k < 10; k++) @(negedge clk);
        xfer_start = 1'b1;
        @(negedge clk);
        xfer_start = 1'b0;
        watch_err(60, got);
        check(got == 22, "R8 second start ignored", got + 10, 32);
    endtask

    task automatic t_disabled();
        int got;
        write_cfg(1'b0, 8'd1, 32'h0);
        pulse_start();
        watch_err(2100, got);
        check(got == 0, "R7 no error when disabled", got, 0);
    endtask

    task automatic t_disable_mid();
        int got;
        write_cfg(1'b1, 8'd3, 32'h0);
        pulse_start();
        for (int k = 1; k < 5; k++) @(negedge clk);
        write_cfg(1'b0, 8'd3, 32'h0);
        write_cfg(1'b1, 8'd3, 32'h0);
        watch_err(100, got);
        check(got == 0, "R7 disable abandons cycle", got, 0);
        pulse_start();
        watch_err(60, got);
        check(got == 24, "R7 fresh cycle after re-enable", got, 24);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state();
        t_reset_limit();
        t_timeout(8'd1, 8, "R3 timing 1");
        t_timeout(8'd7, 56, "R3 timing 7");
        t_timeout(8'd0, 1, "R6 timing 0");
        t_junk_bits();
        t_ack(5, "R5 early ack");
        t_ack(16, "R5 ack on timeout edge");
        t_ack(15, "R5 ack one edge early");
        t_restart_ignored();
        t_disabled();
        t_disable_mid();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                total++;
                bad++;
                $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule